// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block is the part of an 8-bit processor core that decides, at every instruction boundary, whether the next bus cycle is an ordinary opcode fetch or an interrupt acknowledge. It keeps one global interrupt-enable flag. The instruction decoder sets it with an enable strobe and clears it with a disable strobe. One shared active-low request line feeds the block, and no source can be masked on its own. When the flag is set and the request is low at a boundary, the block clears the flag. It then runs an acknowledge cycle in place of the fetch. That cycle has the timing of a memory read, but the acknowledge strobe is asserted instead of the read strobe, and the program counter is not advanced.

The byte read in a fetch or an acknowledge cycle is an instruction. A restart opcode is handled inside the block. It writes the program counter to the stack one byte at a time, high byte first, and then jumps to the restart's fixed vector. Any other opcode is passed to the external decoder, which holds it until it signals completion. Reset clears the enable flag and the stack pointer and starts execution at address zero. Reset writes nothing to the stack.

Top module: `intr_accept_seq`

## Requirements
- R1: While reset is asserted, `rd_n`, `ack_n` and `wr_n` are high, `op_valid` is low and `int_en` is low. After reset the first bus cycle is an opcode fetch at address 0x0000, no stack write comes before it, and the stack pointer starts at 0x0000.
- R2: An enable strobe sets `int_en` and a disable strobe clears it, one cycle after a cycle in which `op_valid` is high. If both strobes are high, disable wins. A strobe in a cycle with `op_valid` low has no effect on `int_en`.
- R3: An acknowledge cycle occurs only when `int_en` was high and `irq_n` was low in the boundary cycle just before it.
- R4: `int_en` is already low in the acknowledge cycle, and no further acknowledge occurs until an enable strobe has been executed.
- R5: An acknowledge cycle holds `ack_n` low for one cycle with `rd_n` high. Its address is the address of the next instruction not yet executed, because the program counter is not advanced.
- R6: A restart opcode is any byte of the form 11nnn111. It causes two consecutive write cycles: the program counter high byte at SP-1, then the low byte at SP-2. SP ends two lower, and the next opcode cycle is at address n*8.
- R7: A restart opcode read by an ordinary fetch behaves the same as one supplied during an acknowledge cycle, and pushes the fetch address plus one.
- R8: A non-restart byte supplied during an acknowledge cycle is presented on `op_code` with `op_valid` high, and the next opcode cycle is at the acknowledge address.
- R9: The request is level-sensitive. A request still low at a boundary with `int_en` high is taken at that boundary, and is never skipped in favour of a fetch.
- R10: At most one of `rd_n`, `ack_n` and `wr_n` is low in any cycle.
- R11: `op_valid` and `op_code` hold steady until `exec_done` is seen, and `op_valid` falls in the cycle after `exec_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; cannot be masked |
| irq_n | input | 1 | Shared active-low interrupt request, level-sensitive |
| ei_stb | input | 1 | Enable strobe from the decoder |
| di_stb | input | 1 | Disable strobe from the decoder |
| exec_done | input | 1 | Decoder has finished the presented opcode |
| bus_din | input | 8 | Data bus input, captured at the end of fetch and acknowledge cycles |
| bus_addr | output | 16 | Bus address |
| bus_dout | output | 8 | Stack write data |
| rd_n | output | 1 | Active-low opcode read strobe |
| ack_n | output | 1 | Active-low interrupt acknowledge strobe |
| wr_n | output | 1 | Active-low stack write strobe |
| op_valid | output | 1 | A non-restart opcode is presented to the decoder |
| op_code | output | 8 | Opcode presented to the decoder |
| int_en | output | 1 | Current state of the global interrupt-enable flag |

## Verification
The assertions check the following on every cycle: strobe exclusivity, the enable and request conditions behind each acknowledge and each fetch, the enable flag being clear during an acknowledge, the rules for when the flag may rise and fall, the pairing and descending addresses of stack writes, and opcode hold against `exec_done`. Only the bench scenarios can show what depends on history: return addresses, restart vector targets, where execution resumes after an acknowledged non-restart byte, the reset start address, and that the flag stays clear until a later enable instruction runs. The bench covers these with a bus-level model that tracks the expected next opcode address and stack pointer.

// File: rtl/ias_pkg.sv
package ias_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2 * DATA_W;
    localparam int RST_NUM_W = 3;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_BOUND,
        ST_FETCH,
        ST_ACK,
        ST_EXEC,
        ST_PUSH_HI,
        ST_PUSH_LO
    } seq_st_e;

    // Restart opcodes have the form 11nnn111.
    function automatic logic is_restart(input byte_t op);
        return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
    endfunction

    function automatic logic [RST_NUM_W-1:0] restart_num(input byte_t op);
        return op[5:3];
    endfunction
endpackage

// File: rtl/ias_ctrl.sv
module ias_ctrl
    import ias_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    irq_n,
    input  logic    ie,
    input  logic    exec_done,
    input  byte_t   din,
    output seq_st_e st,
    output byte_t   op,
    output logic    accept
);
    typedef struct packed {
        seq_st_e st;
        byte_t   op;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        accept = 1'b0;
        unique case (ctrl_q.st)
            ST_BOUND: begin
                accept    = ie && !irq_n;
                ctrl_d.st = accept ? ST_ACK : ST_FETCH;
            end
            ST_FETCH, ST_ACK: begin
                ctrl_d.op = din;
                ctrl_d.st = is_restart(din) ? ST_PUSH_HI : ST_EXEC;
            end
            ST_EXEC: begin
                if (exec_done) ctrl_d.st = ST_BOUND;
            end
            ST_PUSH_HI: ctrl_d.st = ST_PUSH_LO;
            ST_PUSH_LO: ctrl_d.st = ST_BOUND;
            default:    ctrl_d.st = ST_BOUND;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st <= ST_BOUND;
            ctrl_q.op <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign st = ctrl_q.st;
    assign op = ctrl_q.op;
endmodule

// File: rtl/ias_enable.sv
module ias_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic exec_win,
    input  logic ei,
    input  logic di,
    input  logic accept,
    output logic ie
);
    logic ie_d, ie_q;

    always_comb begin
        ie_d = ie_q;
        if (exec_win) begin
            if (di)      ie_d = 1'b0;
            else if (ei) ie_d = 1'b1;
        end
        if (accept) ie_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ie_q <= 1'b0;
        else        ie_q <= ie_d;
    end

    assign ie = ie_q;
endmodule

// File: rtl/ias_ptrs.sv
module ias_ptrs
    import ias_pkg::*;
#(
    parameter addr_t PC_RESET  = '0,
    parameter addr_t SP_RESET  = '0,
    parameter int    VEC_SHIFT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  seq_st_e              st,
    input  logic [RST_NUM_W-1:0] rst_num,
    output addr_t                pc,
    output addr_t                sp
);
    typedef struct packed {
        addr_t pc;
        addr_t sp;
    } ptr_t;

    ptr_t  ptr_d, ptr_q;
    addr_t vec;

    always_comb begin
        vec = '0;
        vec[VEC_SHIFT +: RST_NUM_W] = rst_num;
        ptr_d = ptr_q;
        unique case (st)
            ST_FETCH:   ptr_d.pc = ptr_q.pc + addr_t'(1);
            ST_PUSH_HI: ptr_d.sp = ptr_q.sp - addr_t'(1);
            ST_PUSH_LO: begin
                ptr_d.sp = ptr_q.sp - addr_t'(1);
                ptr_d.pc = vec;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q.pc <= PC_RESET;
            ptr_q.sp <= SP_RESET;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign pc = ptr_q.pc;
    assign sp = ptr_q.sp;
endmodule

// File: rtl/ias_bus.sv
module ias_bus
    import ias_pkg::*;
(
    input  seq_st_e st,
    input  addr_t   pc,
    input  addr_t   sp,
    input  byte_t   op,
    output addr_t   bus_addr,
    output byte_t   bus_dout,
    output logic    rd_n,
    output logic    ack_n,
    output logic    wr_n,
    output logic    op_valid,
    output byte_t   op_code
);
    always_comb begin
        bus_addr = pc;
        bus_dout = '0;
        rd_n     = 1'b1;
        ack_n    = 1'b1;
        wr_n     = 1'b1;
        op_valid = 1'b0;
        op_code  = op;
        unique case (st)
            ST_FETCH: rd_n     = 1'b0;
            ST_ACK:   ack_n    = 1'b0;
            ST_EXEC:  op_valid = 1'b1;
            ST_PUSH_HI, ST_PUSH_LO: begin
                bus_addr = sp - addr_t'(1);
                wr_n     = 1'b0;
                bus_dout = (st == ST_PUSH_HI) ? pc[ADDR_W-1 -: DATA_W] : pc[DATA_W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/intr_accept_seq.sv
module intr_accept_seq
    import ias_pkg::*;
#(
    parameter addr_t PC_RESET  = '0,
    parameter addr_t SP_RESET  = '0,
    parameter int    VEC_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              exec_done,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              rd_n,
    output logic              ack_n,
    output logic              wr_n,
    output logic              op_valid,
    output logic [DATA_W-1:0] op_code,
    output logic              int_en
);
    seq_st_e st;
    byte_t   op_q;
    logic    accept;
    addr_t   pc, sp;

    ias_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_n     (irq_n),
        .ie        (int_en),
        .exec_done (exec_done),
        .din       (bus_din),
        .st        (st),
        .op        (op_q),
        .accept    (accept)
    );

    ias_enable u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_win (st == ST_EXEC),
        .ei       (ei_stb),
        .di       (di_stb),
        .accept   (accept),
        .ie       (int_en)
    );

    ias_ptrs #(
        .PC_RESET  (PC_RESET),
        .SP_RESET  (SP_RESET),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .rst_num (restart_num(op_q)),
        .pc      (pc),
        .sp      (sp)
    );

    ias_bus u_bus (
        .st       (st),
        .pc       (pc),
        .sp       (sp),
        .op       (op_q),
        .bus_addr (bus_addr),
        .bus_dout (bus_dout),
        .rd_n     (rd_n),
        .ack_n    (ack_n),
        .wr_n     (wr_n),
        .op_valid (op_valid),
        .op_code  (op_code)
    );
endmodule

// File: rtl/ias_checker.sv
module ias_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_n,
    input logic        ei_stb,
    input logic        di_stb,
    input logic        exec_done,
    input logic [15:0] bus_addr,
    input logic        rd_n,
    input logic        ack_n,
    input logic        wr_n,
    input logic        op_valid,
    input logic [7:0]  op_code,
    input logic        int_en
);
    p_ack_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> ($past(int_en) && !$past(irq_n)));

    p_fetch_not_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !($past(int_en) && !$past(irq_n)));

    p_accept_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !int_en);

    p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~ack_n, ~wr_n}) <= 1);

    p_push_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(wr_n)) |=> (!wr_n && (bus_addr == $past(bus_addr) - 16'd1)));

    p_push_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !$past(wr_n)) |=> wr_n);

    p_op_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !exec_done) |=> (op_valid && $stable(op_code)));

    p_op_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && exec_done) |=> !op_valid);

    p_di_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && di_stb) |=> !int_en);

    p_ei_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ei_stb && !di_stb) |=> int_en);

    p_en_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_en) |-> $past(op_valid && ei_stb));
endmodule

bind intr_accept_seq ias_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_n     (irq_n),
    .ei_stb    (ei_stb),
    .di_stb    (di_stb),
    .exec_done (exec_done),
    .bus_addr  (bus_addr),
    .rd_n      (rd_n),
    .ack_n     (ack_n),
    .wr_n      (wr_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .int_en    (int_en)
);

// File: tb/intr_accept_seq_tb.sv
module intr_accept_seq_tb;
    import ias_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic  rst_n, irq_n, ei_stb, di_stb, exec_done;
    byte_t bus_din, bus_dout, op_code;
    addr_t bus_addr;
    logic  rd_n, ack_n, wr_n, op_valid, int_en;

    localparam byte_t OP_EI  = 8'hFB;
    localparam byte_t OP_DI  = 8'hF3;
    localparam byte_t OP_NOP = 8'h00;
    localparam addr_t NONE   = 16'hFFFF;

    int checks = 0, errors = 0;

    logic  rand_prog, stray_ei;
    addr_t ei_addr, di_addr, rst_addr;
    byte_t rst_op, ack_byte;
    int    ack_cnt = 0, wr_cnt = 0;

    intr_accept_seq u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .ei_stb(ei_stb), .di_stb(di_stb),
        .exec_done(exec_done), .bus_din(bus_din), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .rd_n(rd_n), .ack_n(ack_n), .wr_n(wr_n), .op_valid(op_valid), .op_code(op_code),
        .int_en(int_en)
    );

    function automatic byte_t prog(input addr_t a);
        if (a == ei_addr)  return OP_EI;
        if (a == di_addr)  return OP_DI;
        if (a == rst_addr) return rst_op;
        if (rand_prog) begin
            if (a % 7 == 3)   return OP_EI;
            if (a % 11 == 5)  return OP_DI;
            if (a % 37 == 20) return {2'b11, a[2:0], 3'b111};
        end
        return OP_NOP;
    endfunction

    function automatic logic rst_like(input byte_t b);
        return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
    endfunction

    always_comb bus_din = !ack_n ? ack_byte : prog(bus_addr);
    always_comb ei_stb  = (op_valid && exec_done && op_code == OP_EI) || stray_ei;
    always_comb di_stb  = op_valid && exec_done && op_code == OP_DI;

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // decoder latency model
    initial begin
        exec_done = 1'b0;
        forever begin
            @(posedge clk);
            #1 exec_done = op_valid && ($urandom_range(0, 2) == 0);
        end
    end

    // bus-level reference monitor
    addr_t exp_next, exp_sp, ret, last_fetch;
    int    push_left, fetch_since_rst;
    byte_t exp_op;
    logic  op_pend, p_irq_n, p_ie, p_opv, p_ei, p_di, p_done;

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(rd_n && ack_n && wr_n && !op_valid && !int_en, "R1", "reset outputs",
                {rd_n, ack_n, wr_n, op_valid, int_en}, 5'b11100);
            exp_next = '0; exp_sp = '0; push_left = 0; op_pend = 1'b0; fetch_since_rst = 0;
            p_irq_n = 1'b1; p_ie = 1'b0; p_opv = 1'b0; p_ei = 1'b0; p_di = 1'b0; p_done = 1'b0;
        end else begin
            if (!rd_n || !ack_n || !wr_n)
                chk($countones({!rd_n, !ack_n, !wr_n}) == 1, "R10", "strobe overlap",
                    {rd_n, ack_n, wr_n}, 0);
            if (!rd_n || !ack_n) begin
                last_fetch = bus_addr;
                chk(push_left == 0, "R6", "opcode cycle inside push", push_left, 0);
                if (fetch_since_rst == 0)
                    chk(bus_addr == 16'h0000 && !rd_n, "R1", "first cycle after reset", bus_addr, 0);
                else
                    chk(bus_addr == exp_next, !ack_n ? "R5" : "R6/R7", "opcode address", bus_addr, exp_next);
                fetch_since_rst++;
                if (!ack_n) begin
                    ack_cnt++;
                    chk(p_ie && !p_irq_n, "R3", "ack without enabled request", {p_ie, p_irq_n}, 2'b10);
                    chk(!int_en, "R4", "enable during ack", int_en, 0);
                end else begin
                    chk(!(p_ie && !p_irq_n), "R9", "pending request skipped", {p_ie, p_irq_n}, 2'b11);
                end
                if (rst_like(bus_din)) begin
                    ret       = !ack_n ? bus_addr : bus_addr + 16'd1;
                    push_left = 2;
                    exp_next  = addr_t'(bus_din[5:3]) << 3;
                end else begin
                    exp_next = !ack_n ? bus_addr : bus_addr + 16'd1;
                    exp_op   = bus_din;
                    op_pend  = 1'b1;
                end
            end
            if (!wr_n) begin
                wr_cnt++;
                if (push_left == 0) begin
                    chk(1'b0, "R6", "unexpected stack write", bus_addr, 0);
                end else begin
                    chk(bus_addr == exp_sp - 16'd1, "R6", "push address", bus_addr, exp_sp - 16'd1);
                    chk(bus_dout == (push_left == 2 ? ret[15:8] : ret[7:0]), "R6", "push data",
                        bus_dout, (push_left == 2 ? ret[15:8] : ret[7:0]));
                    exp_sp = exp_sp - 16'd1;
                    push_left--;
                end
            end
            if (op_valid) begin
                chk(op_pend && op_code == exp_op, "R8", "presented opcode", op_code, exp_op);
                if (exec_done) op_pend = 1'b0;
            end
            if (p_opv && p_done) chk(!op_valid, "R11", "op_valid after done", op_valid, 0);
            if (p_opv && p_di)      chk(!int_en, "R2", "disable strobe", int_en, 0);
            else if (p_opv && p_ei) chk(int_en, "R2", "enable strobe", int_en, 1);
            else if (ack_n)         chk(int_en == p_ie, "R2", "enable changed without strobe", int_en, p_ie);
            p_irq_n = irq_n; p_ie = int_en; p_opv = op_valid;
            p_ei = ei_stb; p_di = di_stb; p_done = exec_done;
        end
    end

    task automatic wait_ack(input int target);
        for (int i = 0; i < 300 && ack_cnt < target; i++) cyc(1);
    endtask

    task automatic wait_wr(input int target);
        for (int i = 0; i < 300 && wr_cnt < target; i++) cyc(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int a0, w0;
        void'($urandom(32'd2024));
        rst_n = 1'b0; irq_n = 1'b1; stray_ei = 1'b0; rand_prog = 1'b0;
        ei_addr = NONE; di_addr = NONE; rst_addr = NONE; rst_op = OP_NOP; ack_byte = OP_NOP;
        cyc(3);
        rst_n = 1'b1;

        // R3: request with enable clear is never taken
        irq_n = 1'b0;
        cyc(60);
        chk(ack_cnt == 0, "R3", "ack while disabled", ack_cnt, 0);

        // R2: enable strobe outside execute window is ignored
        while (op_valid) cyc(1);
        stray_ei = 1'b1;
        cyc(1);
        stray_ei = 1'b0;
        cyc(20);
        chk(!int_en && ack_cnt == 0, "R2", "stray enable", {int_en, ack_cnt[0]}, 0);

        // R4/R5/R6: accept with restart 5
        ack_byte = 8'hEF;
        ei_addr  = last_fetch + 16'd4;
        wait_ack(1);
        ei_addr = NONE;
        cyc(40);
        chk(ack_cnt == 1, "R4", "single ack until enable", ack_cnt, 1);
        chk(wr_cnt == 2, "R6", "two stack writes", wr_cnt, 2);

        // R9: still-low request is retaken after enable, restart 7
        ack_byte = 8'hFF;
        ei_addr  = last_fetch + 16'd4;
        wait_ack(2);
        ei_addr = NONE;
        chk(ack_cnt == 2, "R9", "retake after enable", ack_cnt, 2);
        cyc(10);

        // R8: non-restart byte on acknowledge
        w0 = wr_cnt;
        ack_byte = OP_NOP;
        ei_addr  = last_fetch + 16'd4;
        wait_ack(3);
        ei_addr = NONE;
        cyc(10);
        chk(wr_cnt == w0, "R8", "no push for plain opcode", wr_cnt, w0);

        // R7: restart from memory
        irq_n = 1'b1;
        w0 = wr_cnt;
        rst_op   = 8'hD7;
        rst_addr = last_fetch + 16'd4;
        wait_wr(w0 + 2);
        rst_addr = NONE;
        cyc(6);
        chk(wr_cnt == w0 + 2, "R7", "push from fetched restart", wr_cnt, w0 + 2);

        // R2: disable after enable blocks requests
        a0 = ack_cnt;
        ei_addr = last_fetch + 16'd4;
        di_addr = last_fetch + 16'd6;
        cyc(40);
        ei_addr = NONE; di_addr = NONE;
        irq_n = 1'b0;
        cyc(30);
        chk(ack_cnt == a0 && !int_en, "R2", "disable blocks ack", ack_cnt, a0);

        // R1: reset in mid-run while enabled
        irq_n = 1'b1;
        ei_addr = last_fetch + 16'd4;
        for (int i = 0; i < 100 && !int_en; i++) cyc(1);
        ei_addr = NONE;
        chk(int_en, "R2", "enable reached", int_en, 1);
        rst_n = 1'b0;
        cyc(2);
        chk(!int_en, "R1", "reset clears enable", int_en, 0);
        rst_n = 1'b1;
        cyc(10);

        // random phase
        a0 = ack_cnt;
        rand_prog = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            int r;
            if ($urandom_range(0, 9) < 3) irq_n = ~irq_n;
            r = $urandom_range(0, 9);
            if (r < 7)       ack_byte = {2'b11, 3'($urandom_range(0, 7)), 3'b111};
            else if (r == 7) ack_byte = OP_NOP;
            else if (r == 8) ack_byte = OP_EI;
            else             ack_byte = OP_DI;
            cyc(1);
        end
        chk(ack_cnt > a0, "R3", "random phase took interrupts", ack_cnt - a0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule